// File: doc/BRIEF.md
# Masked Multi-Address Slave Matcher

This block decides whether the address byte that opens a two-wire serial bus transfer selects this device. Software programs four address slots. Each slot holds a 7-bit slave address and a 7-bit don't-care mask. The spare low bit of each address register turns on recognition of the all-zero general-call byte for that slot.

A separate receive front end shifts in the first byte after each START or repeated START. It then pulses a strobe with that byte. On the strobe, the block compares the byte against every slot at once and records the result:

- a match flag;
- a general-call flag;
- the index of the lowest-numbered matching slot;
- the byte that caused the match, with its read/write bit;
- an interrupt request.

The interrupt request stays set until software clears it. Because the front end strobes only the first byte of a transfer, later data bytes never reach the comparator.

Top module: `slave_addr_matcher`

## Requirements
- R1: After synchronous reset, every address register, mask register, flag and the interrupt request is 0, and the held byte is 0x00. With all registers at 0, slot 0 matches a byte whose bits 7:1 are all 0 (0x00 or 0x01), and the general-call flag stays 0.
- R2: A slot matches when every unmasked bit of received bits 7:1 equals the same bit of the slot's address field (register bits 7:1). Received bit 0 is the read/write bit. It never takes part in the comparison and is reported on `rw_bit`.
- R3: A mask register bit at position 7:1 set to 1 removes that address bit from the comparison. Mask register bit 0 has no effect.
- R4: When a slot's address register bit 0 is 1 and the received byte is 0x00, that slot matches and `gc_hit` is 1. With that bit at 0, a 0x00 byte gives no general-call match for that slot.
- R5: When several slots match at once, `hit_slot` reports the lowest-numbered matching slot. `hit` is the OR of all slot matches.
- R6: A strobe that produces any match sets `irq`. `irq` then stays at 1 until a cycle with `irq_clr` high and no matching strobe. A matching strobe in the same cycle as `irq_clr` leaves `irq` at 1.
- R7: `rx_held` and `rw_bit` take the received byte only on a matching strobe. A strobe that matches nothing leaves them unchanged.
- R8: A strobe that matches nothing sets `hit` and `gc_hit` to 0 and `hit_slot` to 0. Without a strobe, `hit`, `gc_hit` and `hit_slot` keep their values.
- R9: A write with `cfg_we` high stores `cfg_wdata`. Select values 0 to 3 address the address registers of slots 0 to 3, and values 4 to 7 address the mask registers of slots 0 to 3. A strobe in the same cycle as a write compares against the values held before that write.
- R10: All outputs show the result of a strobe starting with the first rising clock edge at which the strobe is sampled high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select: 0-3 address slots, 4-7 mask slots |
| cfg_wdata | input | 8 | Register write data |
| rx_strobe | input | 1 | First byte after START has been shifted in |
| rx_byte | input | 8 | Received first byte |
| irq_clr | input | 1 | Interrupt clear strobe |
| hit | output | 1 | Some slot matched the last first byte |
| gc_hit | output | 1 | The last first byte was a recognised general call |
| hit_slot | output | 2 | Lowest matching slot index |
| rx_held | output | 8 | Byte that caused the latest match |
| rw_bit | output | 1 | Read/write bit of the held byte |
| irq | output | 1 | Interrupt request |

## Verification
The checker monitors several properties on every cycle:

- the interrupt rises only after a strobe;
- the interrupt holds until cleared, and falls on a clear without a match;
- a general call always comes with a match and a zero held byte;
- the flags and the held byte stay still between strobes.

Other behaviour can only be shown by the bench's scenarios, which compare each strobe result against a reference model. These are whether a given byte should match under particular masks, the priority among several matching slots, the exclusion of the read/write bit, and the old-versus-new register value when a write and a strobe coincide.

// File: rtl/sam_pkg.sv
package sam_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned ADDR_W = 7;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              gc_en;
    } slot_cfg_t;

    typedef struct packed {
        logic              hit;
        logic              gc;
    } match_flags_t;

    function automatic logic masked_equal(input logic [ADDR_W-1:0] rx_addr,
                                          input logic [ADDR_W-1:0] slot_addr,
                                          input logic [ADDR_W-1:0] dont_care);
        return ((rx_addr ^ slot_addr) & ~dont_care) == '0;
    endfunction

    function automatic logic is_general_call(input logic [BYTE_W-1:0] b);
        return b == '0;
    endfunction

endpackage

// File: rtl/sam_cfg_regs.sv
module sam_cfg_regs
    import sam_pkg::*;
#(
    parameter int unsigned NUM_SLOTS = 4,
    localparam int unsigned SEL_W = $clog2(2 * NUM_SLOTS)
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                we,
    input  logic [SEL_W-1:0]                    sel,
    input  logic [BYTE_W-1:0]                   wdata,
    output slot_cfg_t [NUM_SLOTS-1:0]           slot_q,
    output logic [NUM_SLOTS-1:0][ADDR_W-1:0]    mask_q
);

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q[i] <= '0;
            end else if (we && sel == SEL_W'(i)) begin
                slot_q[i] <= slot_cfg_t'(wdata);
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                mask_q[i] <= '0;
            end else if (we && sel == SEL_W'(NUM_SLOTS + i)) begin
                mask_q[i] <= wdata[BYTE_W-1:1];
            end
        end
    end

endmodule

// File: rtl/sam_slot_cmp.sv
module sam_slot_cmp
    import sam_pkg::*;
#(
    parameter int unsigned NUM_SLOTS = 4
) (
    input  slot_cfg_t [NUM_SLOTS-1:0]           slot_q,
    input  logic [NUM_SLOTS-1:0][ADDR_W-1:0]    mask_q,
    input  logic [BYTE_W-1:0]                   rx_byte,
    output logic [NUM_SLOTS-1:0]                slot_hit,
    output logic [NUM_SLOTS-1:0]                slot_gc
);

    logic gc_byte;
    assign gc_byte = is_general_call(rx_byte);

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_cmp
        logic addr_ok;
        assign addr_ok     = masked_equal(rx_byte[BYTE_W-1:1], slot_q[i].addr, mask_q[i]);
        assign slot_gc[i]  = slot_q[i].gc_en & gc_byte;
        assign slot_hit[i] = addr_ok | slot_gc[i];
    end

endmodule

// File: rtl/sam_prio.sv
module sam_prio #(
    parameter int unsigned NUM_SLOTS = 4,
    localparam int unsigned IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic [NUM_SLOTS-1:0] req,
    output logic                 any,
    output logic [IDX_W-1:0]     idx
);

    always_comb begin
        idx = '0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = IDX_W'(i);
            end
        end
    end

    assign any = |req;

endmodule

// File: rtl/sam_status.sv
module sam_status
    import sam_pkg::*;
#(
    parameter int unsigned IDX_W = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                strobe,
    input  logic                irq_clr,
    input  match_flags_t        flags_in,
    input  logic [IDX_W-1:0]    idx_in,
    input  logic [BYTE_W-1:0]   byte_in,
    output match_flags_t        flags_q,
    output logic [IDX_W-1:0]    idx_q,
    output logic [BYTE_W-1:0]   byte_q,
    output logic                irq_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            idx_q   <= '0;
        end else if (strobe) begin
            flags_q <= flags_in;
            idx_q   <= flags_in.hit ? idx_in : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            byte_q <= '0;
        end else if (strobe && flags_in.hit) begin
            byte_q <= byte_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= 1'b0;
        end else if (strobe && flags_in.hit) begin
            irq_q <= 1'b1;
        end else if (irq_clr) begin
            irq_q <= 1'b0;
        end
    end

endmodule

// File: rtl/slave_addr_matcher.sv
module slave_addr_matcher
    import sam_pkg::*;
#(
    parameter int unsigned NUM_SLOTS = 4,
    localparam int unsigned SEL_W = $clog2(2 * NUM_SLOTS),
    localparam int unsigned IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  logic [SEL_W-1:0]    cfg_sel,
    input  logic [BYTE_W-1:0]   cfg_wdata,
    input  logic                rx_strobe,
    input  logic [BYTE_W-1:0]   rx_byte,
    input  logic                irq_clr,
    output logic                hit,
    output logic                gc_hit,
    output logic [IDX_W-1:0]    hit_slot,
    output logic [BYTE_W-1:0]   rx_held,
    output logic                rw_bit,
    output logic                irq
);

    slot_cfg_t [NUM_SLOTS-1:0]          slot_q;
    logic [NUM_SLOTS-1:0][ADDR_W-1:0]   mask_q;
    logic [NUM_SLOTS-1:0]               slot_hit;
    logic [NUM_SLOTS-1:0]               slot_gc;
    logic                               any_hit;
    logic [IDX_W-1:0]                   first_idx;
    match_flags_t                       flags_d;
    match_flags_t                       flags_q;

    sam_cfg_regs #(.NUM_SLOTS(NUM_SLOTS)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .we     (cfg_we),
        .sel    (cfg_sel),
        .wdata  (cfg_wdata),
        .slot_q (slot_q),
        .mask_q (mask_q)
    );

    sam_slot_cmp #(.NUM_SLOTS(NUM_SLOTS)) u_cmp (
        .slot_q   (slot_q),
        .mask_q   (mask_q),
        .rx_byte  (rx_byte),
        .slot_hit (slot_hit),
        .slot_gc  (slot_gc)
    );

    sam_prio #(.NUM_SLOTS(NUM_SLOTS)) u_prio (
        .req (slot_hit),
        .any (any_hit),
        .idx (first_idx)
    );

    assign flags_d.hit = any_hit;
    assign flags_d.gc  = |slot_gc;

    sam_status #(.IDX_W(IDX_W)) u_stat (
        .clk      (clk),
        .rst      (rst),
        .strobe   (rx_strobe),
        .irq_clr  (irq_clr),
        .flags_in (flags_d),
        .idx_in   (first_idx),
        .byte_in  (rx_byte),
        .flags_q  (flags_q),
        .idx_q    (hit_slot),
        .byte_q   (rx_held),
        .irq_q    (irq)
    );

    assign hit    = flags_q.hit;
    assign gc_hit = flags_q.gc;
    assign rw_bit = rx_held[0];

endmodule

// File: rtl/sam_checker.sv
module sam_checker #(
    parameter int unsigned NUM_SLOTS = 4,
    localparam int unsigned IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input logic             clk,
    input logic             rst,
    input logic             rx_strobe,
    input logic             irq_clr,
    input logic             hit,
    input logic             gc_hit,
    input logic [IDX_W-1:0] hit_slot,
    input logic [7:0]       rx_held,
    input logic             irq
);

    AST_IRQ_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(rx_strobe)) else $error("irq rose without strobe"); // R6

    AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (irq && !irq_clr) |=> irq) else $error("irq dropped without clear"); // R6

    AST_IRQ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (irq_clr && !rx_strobe) |=> !irq) else $error("irq not cleared"); // R6

    AST_GC_WITH_HIT: assert property (@(posedge clk) disable iff (rst)
        gc_hit |-> (hit && rx_held == 8'h00)) else $error("general call inconsistent"); // R4

    AST_QUIET_BETWEEN: assert property (@(posedge clk) disable iff (rst)
        !rx_strobe |=> ($stable(hit) && $stable(gc_hit) && $stable(hit_slot) && $stable(rx_held)))
        else $error("status moved without strobe"); // R8

    AST_HIT_RAISES_IRQ: assert property (@(posedge clk) disable iff (rst)
        (rx_strobe ##1 hit) |-> irq) else $error("match without irq"); // R6

endmodule

bind slave_addr_matcher sam_checker #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .rx_strobe (rx_strobe),
    .irq_clr   (irq_clr),
    .hit       (hit),
    .gc_hit    (gc_hit),
    .hit_slot  (hit_slot),
    .rx_held   (rx_held),
    .irq       (irq)
);

// File: tb/slave_addr_matcher_tb.sv
module slave_addr_matcher_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic       cfg_we;
    logic [2:0] cfg_sel;
    logic [7:0] cfg_wdata;
    logic       rx_strobe;
    logic [7:0] rx_byte;
    logic       irq_clr;
    logic       hit, gc_hit, rw_bit, irq;
    logic [1:0] hit_slot;
    logic [7:0] rx_held;

    always #4 clk = ~clk;

    slave_addr_matcher u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .rx_strobe(rx_strobe), .rx_byte(rx_byte), .irq_clr(irq_clr),
        .hit(hit), .gc_hit(gc_hit), .hit_slot(hit_slot), .rx_held(rx_held),
        .rw_bit(rw_bit), .irq(irq)
    );

    logic [7:0] m_adr [4];
    logic [6:0] m_msk [4];
    logic       m_hit, m_gc, m_irq;
    logic [1:0] m_slot;
    logic [7:0] m_byte;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    function automatic logic slot_match(input int s, input logic [7:0] b);
        logic a;
        a = (((b[7:1] ^ m_adr[s][7:1]) & ~m_msk[s]) == 7'h0);
        return a | (m_adr[s][0] && b == 8'h00);
    endfunction

    function automatic logic [12:0] pack_obs();
        return {hit, gc_hit, hit_slot, rx_held, irq};
    endfunction

    function automatic logic [12:0] pack_exp();
        return {m_hit, m_gc, m_slot, m_byte, m_irq};
    endfunction

    task automatic check(input string req);
        n_checks++;
        if (pack_obs() !== pack_exp() || rw_bit !== m_byte[0]) begin
            n_fail++;
            $display("FAIL %s: actual hit=%0b gc=%0b slot=%0d byte=%02h rw=%0b irq=%0b expected hit=%0b gc=%0b slot=%0d byte=%02h rw=%0b irq=%0b",
                     req, hit, gc_hit, hit_slot, rx_held, rw_bit, irq,
                     m_hit, m_gc, m_slot, m_byte, m_byte[0], m_irq);
        end
    endtask

    // One clock cycle: drive at negedge, update model at posedge, check at next negedge.
    task automatic cyc(input logic we, input logic [2:0] sel, input logic [7:0] wd,
                       input logic stb, input logic [7:0] b, input logic clr, input string req);
        logic any, gcany;
        int   first;
        cfg_we = we; cfg_sel = sel; cfg_wdata = wd;
        rx_strobe = stb; rx_byte = b; irq_clr = clr;
        @(posedge clk);
        any = 0; gcany = 0; first = -1;
        for (int s = 0; s < 4; s++) begin
            if (slot_match(s, b)) begin
                any = 1;
                if (first < 0) first = s;
            end
            if (m_adr[s][0] && b == 8'h00) gcany = 1;
        end
        if (stb) begin
            m_hit  = any;
            m_gc   = gcany;
            m_slot = any ? 2'(first) : 2'd0;
            if (any) m_byte = b;
        end
        if (stb && any) m_irq = 1'b1;
        else if (clr)   m_irq = 1'b0;
        if (we) begin
            if (sel < 3'd4) m_adr[sel[1:0]] = wd;
            else            m_msk[sel[1:0]] = wd[7:1];
        end
        @(negedge clk);
        cfg_we = 0; rx_strobe = 0; irq_clr = 0;
        check(req);
    endtask

    task automatic wr(input logic [2:0] sel, input logic [7:0] wd);
        cyc(1'b1, sel, wd, 1'b0, 8'h00, 1'b0, "R9");
    endtask

    task automatic rx(input logic [7:0] b, input string req);
        cyc(1'b0, 3'd0, 8'h00, 1'b1, b, 1'b0, req);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd24681));
        for (int s = 0; s < 4; s++) begin m_adr[s] = 0; m_msk[s] = 0; end
        m_hit = 0; m_gc = 0; m_irq = 0; m_slot = 0; m_byte = 0;
        rst = 1; cfg_we = 0; cfg_sel = 0; cfg_wdata = 0;
        rx_strobe = 0; rx_byte = 0; irq_clr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        check("R1 reset state");

        // R1: registers all zero, so 0x02 misses and 0x01 hits slot 0 without general call
        rx(8'h02, "R1 zero regs miss");
        rx(8'h01, "R1 zero regs hit slot0");
        cyc(1'b0, 3'd0, 8'h00, 1'b0, 8'h00, 1'b1, "R6 clear");

        // R2: exact address compare, bit 0 excluded
        wr(3'd0, 8'hA0);
        wr(3'd1, 8'h30);
        wr(3'd5, 8'h1F);           // slot1 mask bits 4:1 in address field, bit 0 ignored (R3)
        wr(3'd2, 8'hA0);
        wr(3'd3, 8'h7E);
        rx(8'hA0, "R2 write match");
        rx(8'hA1, "R2 read bit ignored");
        rx(8'hA2, "R8 miss clears flags / R7 byte kept");
        rx(8'h3E, "R3 masked bits ignored");
        rx(8'h31, "R3 masked match low");
        rx(8'h70, "R3 unmasked bit differs");
        rx(8'hA0, "R5 slot0 and slot2 match, lowest wins");
        wr(3'd0, 8'h10);
        rx(8'hA0, "R5 only slot2 now");
        // R4 general call
        rx(8'h00, "R4 gc disabled");
        wr(3'd3, 8'h7F);
        rx(8'h00, "R4 gc enabled slot3");
        wr(3'd1, 8'h31);
        rx(8'h00, "R4 gc lowest slot");
        // R6 irq handling
        cyc(1'b0, 3'd0, 8'h00, 1'b0, 8'h00, 1'b0, "R6 irq holds");
        cyc(1'b0, 3'd0, 8'h00, 1'b0, 8'h00, 1'b1, "R6 irq cleared");
        cyc(1'b0, 3'd0, 8'h00, 1'b1, 8'hA0, 1'b1, "R6 set beats clear");
        cyc(1'b0, 3'd0, 8'h00, 1'b1, 8'h55, 1'b1, "R6 miss with clear");
        // R9 write collides with strobe: old slot2 value used
        cyc(1'b1, 3'd2, 8'h22, 1'b1, 8'hA1, 1'b0, "R9 old value used");
        rx(8'hA1, "R9 new value in effect");
        rx(8'h23, "R10 new value match");

        // Constrained random mix
        for (int it = 0; it < 600; it++) begin
            int unsigned op;
            logic [7:0] b;
            int s;
            op = $urandom_range(0, 9);
            s  = $urandom_range(0, 3);
            if (op < 2) begin
                wr(3'($urandom_range(0, 7)), 8'($urandom));
            end else if (op < 3) begin
                cyc(1'b0, 3'd0, 8'h00, 1'b0, 8'h00, 1'b1, "R6 random clear");
            end else if (op < 4) begin
                rx(8'h00, "R4 random gc");
            end else if (op < 7) begin
                b = {m_adr[s][7:1] ^ (7'($urandom) & m_msk[s]), 1'($urandom)};
                rx(b, "R2 R3 R5 random near match");
            end else begin
                cyc(1'b0, 3'd0, 8'h00, 1'($urandom), 8'($urandom), 1'($urandom),
                    "R7 R8 random");
            end
        end

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule